// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block carries 32-bit register writes from a fast bus clock into registers that run from a slow, roughly 32 kHz, domain. A write to any synchronized address is captured and held in the bus domain. A toggle request crosses into the slow domain, where the write is presented once on a simple write port. A toggle acknowledge then crosses back, and that ends the transaction.

Software follows each write through a status word. The word carries a busy flag, a ready-for-next flag, a completion flag and an error flag. The completion flag clears itself when the status word is read. One address, the interrupt-enable register, bypasses the crossing: it takes effect at bus speed and never produces a completion. An interrupt output combines the three flag sources, each gated by its own enable bit.

Top module: `lp_write_bridge`

## Requirements
- R1: After reset, the status word at address 0x14 reads 0x200 (only the ready bit set), the enable register at 0x18 reads 0, and `irq` is low.
- R2: A write to any address other than 0x18, accepted while idle, appears on the slow port exactly once, with the same address and data. Address and data are held unchanged in the bus domain until the acknowledge returns.
- R3: Status bit 10 (busy) is set from the accepting bus edge until the returning acknowledge is seen. Status bit 9 (ready) is its inverse.
- R4: When the acknowledge of a synchronized write arrives, status bit 8 (complete) is set. It is set by nothing else.
- R5: A status read clears bit 8. If a completion arrives on the same cycle as the read, the bit stays set.
- R6: A write to 0x18 updates the enable register on the next bus edge, even while busy. It never reaches the slow port and never sets bit 8. Only data bits 9, 8 and 7 are stored, and they read back in the same positions.
- R7: A synchronized write that arrives while busy is dropped (nothing reaches the slow port) and sets status bit 7 (error).
- R8: A synchronized write to 0x14 with data bit 7 set clears the error flag when its acknowledge returns. Until then the flag stays set. A write to 0x14 with bit 7 clear leaves the flag unchanged.
- R9: `irq` is registered. It is high one cycle after any of these holds: enable bit 9 with ready, enable bit 8 with complete, or enable bit 7 with error.
- R10: `rd_data` is valid on the cycle after `rd_en`. Addresses other than 0x14 and 0x18 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write byte address |
| wr_data | input | DATA_W | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read byte address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |
| slow_clk | input | 1 | Slow domain clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| slow_we | output | 1 | One-cycle commit strobe in slow domain |
| slow_addr | output | ADDR_W | Committed address |
| slow_wdata | output | DATA_W | Committed data |

## Verification
A request toggle that is lost, or a busy flag that sticks, shows within a few slow cycles: the status poll never reports idle, or the slow port sees too few or too many commits. A hold register that changes during a crossing shows as a wrong address or data on the single commit. A completion or error flag in the wrong state shows on the very next status read, and on `irq` one bus cycle after its enable is set. Because of this, every sweep vector checks the busy read right after the write, the final poll, the slow-port capture and the read that follows completion.

// File: rtl/lpwb_pkg.sv
package lpwb_pkg;
  localparam int ST_BUSY  = 10;
  localparam int ST_READY = 9;
  localparam int ST_DONE  = 8;
  localparam int ST_ERR   = 7;
  localparam int IE_BITS  = 3;
endpackage

// File: rtl/lpwb_sync.sv
module lpwb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpwb_req_ctl.sv
module lpwb_req_ctl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] IE_ADDR = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              busy,
  output logic              done,
  output logic              drop
);
  logic ack_sync, ack_seen, sync_wr, accept;

  lpwb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_sync)
  );

  assign sync_wr = wr_en && (wr_addr != IE_ADDR);
  assign accept  = sync_wr && !busy;
  assign drop    = sync_wr && busy;
  assign done    = ack_sync ^ ack_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      busy      <= 1'b0;
      ack_seen  <= 1'b0;
    end else begin
      ack_seen <= ack_sync;
      if (accept) begin
        req_tgl   <= ~req_tgl;
        hold_addr <= wr_addr;
        hold_data <= wr_data;
        busy      <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  // R2: held write stays stable for the whole crossing
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(hold_addr) && $stable(hold_data) && $stable(req_tgl)));

  // R3: returning acknowledge ends the busy window
  a_r3_busy_clears: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/lpwb_slow_commit.sv
module lpwb_slow_commit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              ack_tgl,
  output logic              slow_we,
  output logic [ADDR_W-1:0] slow_addr,
  output logic [DATA_W-1:0] slow_wdata
);
  logic req_sync, req_seen, fire;

  lpwb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_tgl), .q(req_sync)
  );

  assign fire = req_sync ^ req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen   <= 1'b0;
      ack_tgl    <= 1'b0;
      slow_we    <= 1'b0;
      slow_addr  <= '0;
      slow_wdata <= '0;
    end else begin
      req_seen <= req_sync;
      slow_we  <= fire;
      if (fire) begin
        slow_addr  <= hold_addr;
        slow_wdata <= hold_data;
        ack_tgl    <= ~ack_tgl;
      end
    end
  end

  // R2: each request commits for a single slow cycle
  a_r2_single_commit: assert property (@(posedge clk) disable iff (rst)
    slow_we |=> !slow_we);
endmodule

// File: rtl/lpwb_flags.sv
module lpwb_flags
  import lpwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] IE_ADDR   = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              done,
  input  logic              drop,
  input  logic [ADDR_W-1:0] done_addr,
  input  logic [DATA_W-1:0] done_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [IE_BITS-1:0] ie_q;
  logic wcf_q, wef_q, ie_wr, stat_rd, err_clr;
  logic [DATA_W-1:0] status_w, ie_w;

  assign ie_wr   = wr_en && (wr_addr == IE_ADDR);
  assign stat_rd = rd_en && (rd_addr == STAT_ADDR);
  assign err_clr = done && (done_addr == STAT_ADDR) && done_data[ST_ERR];

  always_comb begin
    status_w = '0;
    status_w[ST_BUSY]  = busy;
    status_w[ST_READY] = !busy;
    status_w[ST_DONE]  = wcf_q;
    status_w[ST_ERR]   = wef_q;
    ie_w = '0;
    ie_w[ST_READY] = ie_q[2];
    ie_w[ST_DONE]  = ie_q[1];
    ie_w[ST_ERR]   = ie_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= '0;
      wcf_q   <= 1'b0;
      wef_q   <= 1'b0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (ie_wr) ie_q <= {wr_data[ST_READY], wr_data[ST_DONE], wr_data[ST_ERR]};
      if (done)         wcf_q <= 1'b1;
      else if (stat_rd) wcf_q <= 1'b0;
      if (drop)         wef_q <= 1'b1;
      else if (err_clr) wef_q <= 1'b0;
      if (rd_en) begin
        if (rd_addr == STAT_ADDR)    rd_data <= status_w;
        else if (rd_addr == IE_ADDR) rd_data <= ie_w;
        else                         rd_data <= '0;
      end
      irq <= (ie_q[2] && !busy) || (ie_q[1] && wcf_q) || (ie_q[0] && wef_q);
    end
  end

  // R4: complete flag only rises after an acknowledge
  a_r4_done_source: assert property (@(posedge clk) disable iff (rst)
    $rose(wcf_q) |-> $past(done));

  // R5: completion coinciding with a status read survives
  a_r5_done_wins: assert property (@(posedge clk) disable iff (rst)
    (done && stat_rd) |=> wcf_q);

  // R7: a dropped write raises the error flag
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (rst)
    drop |=> wef_q);

  // R9: enabled completion drives the interrupt
  a_r9_irq_complete: assert property (@(posedge clk) disable iff (rst)
    (ie_q[1] && wcf_q) |=> irq);
endmodule

// File: rtl/lp_write_bridge.sv
module lp_write_bridge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] IE_ADDR   = 8'h18
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  input  logic              slow_clk,
  input  logic              slow_rst,
  output logic              slow_we,
  output logic [ADDR_W-1:0] slow_addr,
  output logic [DATA_W-1:0] slow_wdata
);
  logic req_tgl, ack_tgl, busy, done, drop;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  lpwb_req_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .IE_ADDR(IE_ADDR)
  ) u_req (
    .clk(bus_clk), .rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_tgl(ack_tgl), .req_tgl(req_tgl),
    .hold_addr(hold_addr), .hold_data(hold_data), .busy(busy),
    .done(done), .drop(drop)
  );

  lpwb_slow_commit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_slow (
    .clk(slow_clk), .rst(slow_rst), .req_tgl(req_tgl),
    .hold_addr(hold_addr), .hold_data(hold_data), .ack_tgl(ack_tgl),
    .slow_we(slow_we), .slow_addr(slow_addr), .slow_wdata(slow_wdata)
  );

  lpwb_flags #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .IE_ADDR(IE_ADDR)
  ) u_flags (
    .clk(bus_clk), .rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
    .done(done), .drop(drop), .done_addr(hold_addr), .done_data(hold_data),
    .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: tb/sim_lp_write_bridge.sv
module sim_lp_write_bridge;
  logic bus_clk = 1'b0, slow_clk = 1'b0;
  logic bus_rst = 1'b1, slow_rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq, slow_we;
  logic [7:0] slow_addr;
  logic [31:0] slow_wdata;

  int n_vec = 0, n_bad = 0;
  int commits = 0;
  logic [7:0] last_addr = '0;
  logic [31:0] last_data = '0;

  always #10 bus_clk = ~bus_clk;
  always #70 slow_clk = ~slow_clk;

  lp_write_bridge u0 (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .slow_clk(slow_clk), .slow_rst(slow_rst), .slow_we(slow_we),
    .slow_addr(slow_addr), .slow_wdata(slow_wdata)
  );

  always @(negedge slow_clk) begin
    if (slow_we) begin
      commits++;
      last_addr = slow_addr;
      last_data = slow_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge bus_clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h400;
    for (int k = 0; k < 300; k++) begin
      bus_read(8'h14, st);
      if (!st[10]) break;
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] st, v, d;
    logic [7:0] a;
    int c0;
    repeat (4) @(negedge slow_clk);
    slow_rst = 1'b0;
    @(negedge bus_clk);
    bus_rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    bus_read(8'h14, v); check("R1 status", v, 32'h200);
    bus_read(8'h18, v); check("R1 enables", v, 32'h0);
    // R10 unmapped read
    bus_read(8'h00, v); check("R10 unmapped", v, 32'h0);

    // R2 R3 R4 R5 sweep of synchronized writes
    for (int i = 0; i < 48; i++) begin
      a = 8'((i * 12) + 4);
      if (a == 8'h18) a = 8'h1c;
      d = (32'(i) * 32'h9E3779B9) + 32'h1;
      if (a == 8'h14) d = d & ~32'h80;
      c0 = commits;
      bus_write(a, d);
      bus_read(8'h14, v); check("R3 busy after write", v, 32'h400);
      wait_idle(st); check("R4 complete on idle", st, 32'h300);
      check("R2 commit count", 32'(commits - c0), 32'd1);
      check("R2 commit addr", {24'd0, last_addr}, {24'd0, a});
      check("R2 commit data", last_data, d);
      bus_read(8'h14, v); check("R5 cleared by read", v, 32'h200);
    end

    // R6 enable register at bus speed
    c0 = commits;
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_read(8'h18, v); check("R6 enable readback", v, 32'h380);
    idle_cycles(40);
    bus_read(8'h14, v); check("R6 no complete", v, 32'h200);
    check("R6 no commit", 32'(commits - c0), 32'd0);
    bus_write(8'h18, 32'h0);
    idle_cycles(3);

    // R6 enable write while busy, then R9 completion interrupt
    bus_write(8'h20, 32'hA5A5_0001);
    bus_write(8'h18, 32'h100);
    bus_read(8'h18, v); check("R6 enable while busy", v, 32'h100);
    bus_read(8'h14, v); check("R6 busy no error", v, 32'h400);
    idle_cycles(100);
    check("R9 irq on complete", {31'd0, irq}, 32'd1);
    bus_read(8'h14, v); check("R4 complete", v, 32'h300);
    idle_cycles(3);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);
    bus_write(8'h18, 32'h0);

    // R7 write while busy is dropped
    c0 = commits;
    bus_write(8'h30, 32'h1111_2222);
    bus_write(8'h34, 32'h3333_4444);
    wait_idle(st); check("R7 error set", st, 32'h380);
    check("R7 one commit", 32'(commits - c0), 32'd1);
    check("R7 first kept", last_data, 32'h1111_2222);
    bus_read(8'h14, v); check("R7 error persists", v, 32'h280);

    // R9 error interrupt
    bus_write(8'h18, 32'h80);
    idle_cycles(3);
    check("R9 irq on error", {31'd0, irq}, 32'd1);
    bus_write(8'h18, 32'h0);
    idle_cycles(3);
    check("R9 irq masked", {31'd0, irq}, 32'd0);

    // R8 clearing the error
    bus_write(8'h14, 32'h0);
    wait_idle(st); check("R8 bit7 clear keeps error", st, 32'h380);
    c0 = commits;
    bus_write(8'h14, 32'h80);
    bus_read(8'h14, v); check("R8 error held while busy", v, 32'h480);
    wait_idle(st); check("R8 error cleared", st, 32'h300);
    check("R8 clear passes slow port", 32'(commits - c0), 32'd1);

    // R9 ready interrupt
    bus_write(8'h18, 32'h200);
    idle_cycles(3);
    check("R9 irq on ready", {31'd0, irq}, 32'd1);
    bus_write(8'h40, 32'h5);
    idle_cycles(2);
    check("R9 irq off while busy", {31'd0, irq}, 32'd0);
    wait_idle(st);
    bus_write(8'h18, 32'h0);

    // R10 unmapped address after traffic
    bus_read(8'h40, v); check("R10 unmapped after writes", v, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule